// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves single characters between a host and an asynchronous smart card over one shared, open-drain I/O line. It derives the card clock from the system clock with a programmable divisor and measures each elementary time unit (etu) as a programmable number of card-clock cycles. A character on the line is a low start bit, eight data bits sent LSB first, an even parity bit and a high stop period. After each sent character the transmitter holds the line idle for extra guard etus.

The host hands over bytes to send through a valid/ready pair and takes received bytes through a second valid/ready pair. A six-bit sticky status vector collects error events. The block is half-duplex. Offering a byte while receiving turns the line around to transmit. Asserting `rx_ready_i` while transmitting turns it back, but only once the transmitter, including its guard time, has gone idle. Both turnarounds wipe the status vector. When the receiver sees bad parity, it pulls the line low for one etu to ask the card to repeat. When the transmitter sees the card do the same, it reports a NACK.

Top module: `sc_xcvr`

## Requirements
- R1: After reset the divisor is 13, the etu is 372 card clocks, the guard is 5 etu and the timeout is 0 (disabled). The line is released, `tx_ready_o` is 1, `rx_valid_o` is 0, `status_o` is 0 and the block is in receive direction.
- R2: With a nonzero divisor D, `sck_o` has a period of D system cycles and is high for floor(D/2) of them. Writing D=0 holds `sck_o` low and stops all etu timing. Writing a nonzero value starts it again.
- R3: One etu lasts the configured number of card-clock periods. Configuration writes use `cfg_addr_i` 0 for the divisor, 1 for the etu length, 2 for the guard etus and 3 for the timeout in etus.
- R4: A sent character drives the line low for the start bit, then the 8 data bits LSB first, then even parity, and then releases the line. `io_low_o`=1 pulls the line low and 0 releases it.
- R5: After a byte is accepted, `tx_ready_o` returns to 1 after 12 plus guard etus.
- R6: If the line is low at the start of etu 11 of a sent character, `status_o[4]` (NACK) is set.
- R7: A received character whose parity is correct and whose line is high at mid-etu 10 is presented on `rx_data_o` with `rx_valid_o`=1, and the block does not drive the line during it.
- R8: A received character with a parity error sets `status_o[2]`, is not presented, and makes the block pull the line low for one etu starting at mid-etu 10.
- R9: A received character with correct parity but a low line at mid-etu 10 sets `status_o[1]` (framing) and is not presented.
- R10: A character that completes while `rx_valid_o` is 1 and `rx_ready_i` is 0 sets `status_o[0]` (overrun), and `rx_data_o` keeps the earlier byte.
- R11: In receive direction, while `rx_ready_i` is 1, no byte is held and the receiver is idle, a nonzero timeout of T etus sets `status_o[3]` after T etus.
- R12: Accepting a byte in receive direction switches to transmit and clears `status_o`. In transmit direction, `rx_ready_i`=1 with the transmitter idle after its guard time switches to receive and clears `status_o`.
- R13: A character in progress while the divisor is 0 sets `status_o[5]` (transmit underrun).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration select: 0 divisor, 1 etu, 2 guard, 3 timeout |
| cfg_wdata_i | input | 16 | Configuration write value |
| sck_o | output | 1 | Card clock |
| io_i | input | 1 | Level of the shared I/O line |
| io_low_o | output | 1 | Pull the I/O line low |
| tx_valid_i | input | 1 | Byte to send is offered |
| tx_ready_o | output | 1 | Transmitter can take a byte |
| tx_data_i | input | 8 | Byte to send |
| rx_valid_o | output | 1 | Received byte is held |
| rx_ready_i | input | 1 | Host takes the held byte; also requests receive direction |
| rx_data_o | output | 8 | Received byte |
| status_o | output | 6 | Sticky flags: 0 overrun, 1 framing, 2 parity, 3 timeout, 4 NACK, 5 underrun |

## Verification
A wrong etu or divisor count shows up at once in the length of the start bit on the line and in the `sck_o` period. Within one character it also shows as misplaced data or parity bits, and as a `tx_ready_o` return that is early or late by whole etus. A receiver whose sample point or bit index is off delivers a wrong byte, or raises a parity or framing flag, at mid-etu 9 or 10 of the incoming character. It also moves or drops the one-etu NACK pulse the bench measures on `io_low_o`. A direction or status fault appears at the turnaround itself, as flags that survive the switch or a NACK missed at etu 11.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int ST_W    = 6;
  localparam int ST_OVR  = 0;
  localparam int ST_FRM  = 1;
  localparam int ST_PAR  = 2;
  localparam int ST_TMO  = 3;
  localparam int ST_NACK = 4;
  localparam int ST_UND  = 5;

  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;
  typedef enum logic [1:0] {
    CFG_DIV = 2'd0,
    CFG_ETU = 2'd1,
    CFG_GT  = 2'd2,
    CFG_TMO = 2'd3
  } cfg_e;
endpackage

// File: rtl/sc_clkgen.sv
module sc_clkgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             sck_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             run;

  assign run    = (div_i != '0);
  assign tick_o = run && (cnt_q >= div_i - 1'b1);
  assign sck_o  = run && (cnt_q < (div_i >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run || tick_o)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  // R2: counter stays inside the divisor window
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $stable(div_i)) |-> (cnt_q < div_i));
endmodule

// File: rtl/sc_tx.sv
module sc_tx #(
  parameter int ETU_W = 16,
  parameter int GT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [ETU_W-1:0] etu_i,
  input  logic [GT_W-1:0]  guard_i,
  input  logic             start_i,
  input  logic [7:0]       data_i,
  input  logic             io_i,
  input  logic             clk_stop_i,
  output logic             busy_o,
  output logic             low_o,
  output logic             nack_o,
  output logic             stall_o
);
  localparam int IDX_W = GT_W + 1;

  logic             busy_q;
  logic [ETU_W-1:0] sub_q, etu_m1;
  logic [IDX_W-1:0] idx_q, last_idx;
  logic [9:0]       frame_q;
  logic             etu_end;

  assign etu_m1   = (etu_i == '0) ? '0 : etu_i - 1'b1;
  assign last_idx = IDX_W'(guard_i) + IDX_W'(11);
  assign etu_end  = busy_q && tick_i && (sub_q >= etu_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sub_q   <= '0;
      idx_q   <= '0;
      frame_q <= '1;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        sub_q   <= '0;
        idx_q   <= '0;
        frame_q <= {^data_i, data_i, 1'b0};
      end
    end else if (tick_i) begin
      if (sub_q >= etu_m1) begin
        sub_q   <= '0;
        frame_q <= {1'b1, frame_q[9:1]};
        if (idx_q >= last_idx) busy_q <= 1'b0;
        else                   idx_q  <= idx_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign low_o   = busy_q && !frame_q[0];
  assign nack_o  = etu_end && (idx_q == IDX_W'(10)) && !io_i;
  assign stall_o = busy_q && clk_stop_i;

  // R4: first cycle of a character is the start bit
  a_r4_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> low_o);
  // R4: line released once parity has gone out
  a_r4_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q >= IDX_W'(10)) |-> !low_o);
endmodule

// File: rtl/sc_rx.sv
module sc_rx #(
  parameter int ETU_W = 16,
  parameter int TO_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [ETU_W-1:0] etu_i,
  input  logic [TO_W-1:0]  tmo_i,
  input  logic             en_i,
  input  logic             wait_i,
  input  logic             io_i,
  output logic             busy_o,
  output logic             low_o,
  output logic [7:0]       byte_o,
  output logic             byte_ev_o,
  output logic             par_ev_o,
  output logic             frm_ev_o,
  output logic             tmo_ev_o
);
  logic             busy_q, prev_q, bad_q, nack_q, fired_q;
  logic [ETU_W-1:0] sub_q, tsub_q, etu_m1, half;
  logic [3:0]       idx_q;
  logic [7:0]       sh_q;
  logic [TO_W-1:0]  tcnt_q;
  logic             mid, armed, t_end;

  assign etu_m1 = (etu_i == '0) ? '0 : etu_i - 1'b1;
  assign half   = etu_i >> 1;
  assign mid    = busy_q && tick_i && (sub_q == half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      prev_q <= 1'b1;
      bad_q  <= 1'b0;
      nack_q <= 1'b0;
      sub_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else begin
      prev_q <= io_i;
      if (!busy_q) begin
        nack_q <= 1'b0;
        if (en_i && prev_q && !io_i) begin
          busy_q <= 1'b1;
          sub_q  <= '0;
          idx_q  <= '0;
          bad_q  <= 1'b0;
        end
      end else begin
        if (tick_i) begin
          if (sub_q >= etu_m1) begin
            sub_q <= '0;
            idx_q <= idx_q + 1'b1;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        if (mid) begin
          if (idx_q == 4'd0) begin
            if (io_i) busy_q <= 1'b0;       // glitch, not a start bit
          end else if (idx_q <= 4'd8) begin
            sh_q <= {io_i, sh_q[7:1]};
          end else if (idx_q == 4'd9) begin
            bad_q <= io_i ^ (^sh_q);
          end else if (idx_q == 4'd10) begin
            nack_q <= bad_q;
          end else begin
            nack_q <= 1'b0;
            busy_q <= 1'b0;
          end
        end
      end
    end
  end

  assign byte_ev_o = mid && (idx_q == 4'd10) && !bad_q && io_i;
  assign frm_ev_o  = mid && (idx_q == 4'd10) && !bad_q && !io_i;
  assign par_ev_o  = mid && (idx_q == 4'd9) && (io_i ^ (^sh_q));
  assign byte_o    = sh_q;
  assign busy_o    = busy_q;
  assign low_o     = nack_q;

  // receive wait timer, counted in etus
  assign armed    = en_i && wait_i && (tmo_i != '0) && !busy_q;
  assign t_end    = armed && !fired_q && tick_i && (tsub_q >= etu_m1);
  assign tmo_ev_o = t_end && (tcnt_q == tmo_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tsub_q  <= '0;
      tcnt_q  <= '0;
      fired_q <= 1'b0;
    end else if (!armed) begin
      tsub_q  <= '0;
      tcnt_q  <= '0;
      fired_q <= 1'b0;
    end else if (tmo_ev_o) begin
      fired_q <= 1'b1;
    end else if (t_end) begin
      tsub_q <= '0;
      tcnt_q <= tcnt_q + 1'b1;
    end else if (tick_i && !fired_q) begin
      tsub_q <= tsub_q + 1'b1;
    end
  end

  // R8: error pulse only inside a character
  a_r8_nack_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_q |-> busy_q);
  // R7: a good character never triggers the error pulse
  a_r7_quiet_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ev_o |=> !nack_q);
  // R11: one timeout event per wait
  a_r11_tmo_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_ev_o |=> !tmo_ev_o);
endmodule

// File: rtl/sc_xcvr.sv
module sc_xcvr
  import sc_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int ETU_W   = 16,
  parameter int GT_W    = 8,
  parameter int TO_W    = 16,
  parameter int CFG_W   = 16,
  parameter int DIV_RST = 13,
  parameter int ETU_RST = 372,
  parameter int GT_RST  = 5,
  parameter int TO_RST  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             sck_o,
  input  logic             io_i,
  output logic             io_low_o,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  input  logic [7:0]       tx_data_i,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  output logic [7:0]       rx_data_o,
  output logic [ST_W-1:0]  status_o
);
  logic [DIV_W-1:0] div_q;
  logic [ETU_W-1:0] etu_q;
  logic [GT_W-1:0]  gt_q;
  logic [TO_W-1:0]  tmo_q;
  dir_e             dir_q;
  logic [1:0]       io_sync_q;
  logic             io_s, tick;
  logic             tx_busy, tx_low, tx_nack, tx_stall, tx_accept;
  logic             rx_busy, rx_low, byte_ev, par_ev, frm_ev, tmo_ev;
  logic [7:0]       rx_byte, rx_data_q;
  logic             rx_valid_q, ovr_ev, sw_rx, clr;
  logic [ST_W-1:0]  status_q, ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIV_W'(DIV_RST);
      etu_q <= ETU_W'(ETU_RST);
      gt_q  <= GT_W'(GT_RST);
      tmo_q <= TO_W'(TO_RST);
    end else if (cfg_we_i) begin
      unique case (cfg_e'(cfg_addr_i))
        CFG_DIV: div_q <= DIV_W'(cfg_wdata_i);
        CFG_ETU: etu_q <= ETU_W'(cfg_wdata_i);
        CFG_GT:  gt_q  <= GT_W'(cfg_wdata_i);
        CFG_TMO: tmo_q <= TO_W'(cfg_wdata_i);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) io_sync_q <= 2'b11;
    else         io_sync_q <= {io_sync_q[0], io_i};
  end
  assign io_s = io_sync_q[1];

  sc_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk_i (clk_i), .rst_ni (rst_ni), .div_i (div_q),
    .tick_o(tick),  .sck_o  (sck_o)
  );

  sc_tx #(.ETU_W(ETU_W), .GT_W(GT_W)) u_tx (
    .clk_i     (clk_i),     .rst_ni (rst_ni),  .tick_i (tick),
    .etu_i     (etu_q),     .guard_i(gt_q),    .start_i(tx_accept),
    .data_i    (tx_data_i), .io_i   (io_s),    .clk_stop_i(div_q == '0),
    .busy_o    (tx_busy),   .low_o  (tx_low),  .nack_o (tx_nack),
    .stall_o   (tx_stall)
  );

  sc_rx #(.ETU_W(ETU_W), .TO_W(TO_W)) u_rx (
    .clk_i    (clk_i),   .rst_ni  (rst_ni),  .tick_i  (tick),
    .etu_i    (etu_q),   .tmo_i   (tmo_q),   .en_i    (dir_q == DIR_RX),
    .wait_i   (rx_ready_i && !rx_valid_q),   .io_i    (io_s),
    .busy_o   (rx_busy), .low_o   (rx_low),  .byte_o  (rx_byte),
    .byte_ev_o(byte_ev), .par_ev_o(par_ev),  .frm_ev_o(frm_ev),
    .tmo_ev_o (tmo_ev)
  );

  assign tx_ready_o = !tx_busy && !((dir_q == DIR_RX) && rx_busy);
  assign tx_accept  = tx_valid_i && tx_ready_o;
  assign sw_rx      = (dir_q == DIR_TX) && rx_ready_i && !tx_busy && !tx_valid_i;
  assign clr        = sw_rx || (tx_accept && dir_q == DIR_RX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dir_q <= DIR_RX;
    else if (tx_accept) dir_q <= DIR_TX;
    else if (sw_rx)     dir_q <= DIR_RX;
  end

  // receive holding register
  assign ovr_ev = byte_ev && rx_valid_q && !rx_ready_i;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else if (byte_ev && !ovr_ev) begin
      rx_valid_q <= 1'b1;
      rx_data_q  <= rx_byte;
    end else if (rx_ready_i) begin
      rx_valid_q <= 1'b0;
    end
  end

  always_comb begin
    ev          = '0;
    ev[ST_OVR]  = ovr_ev;
    ev[ST_FRM]  = frm_ev;
    ev[ST_PAR]  = par_ev;
    ev[ST_TMO]  = tmo_ev;
    ev[ST_NACK] = tx_nack;
    ev[ST_UND]  = tx_stall;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  status_q <= '0;
    else if (clr) status_q <= '0;
    else          status_q <= status_q | ev;
  end

  assign io_low_o   = tx_low | rx_low;
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
  assign status_o   = status_q;

  // R12: turnaround to receive wipes the flags
  a_r12_clear_on_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rx |=> (status_q == '0));
  // R4: transmitter and receiver never drive the line together
  a_r4_one_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_low && rx_low));
  // R10: overrun keeps the held byte
  a_r10_keep_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_ev |=> ($stable(rx_data_q) && rx_valid_q));
endmodule

// File: tb/sim_sc_xcvr.sv
`timescale 1ns/1ps
module sim_sc_xcvr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic        sck, io_low, tx_ready, rx_valid;
  logic        tx_valid = 1'b0, rx_ready = 1'b0, card_low = 1'b0;
  logic [7:0]  tx_data = '0, rx_data;
  logic [5:0]  status;
  logic        line;
  int          checks = 0, errors = 0;

  localparam int E = 32;  // etu in system cycles after reconfiguration

  always #2.5 clk = ~clk;
  assign line = !(io_low | card_low);

  sc_xcvr u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .sck_o(sck), .io_i(line), .io_low_o(io_low),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data),
    .status_o(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] a, input logic [15:0] v);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    int n;
    n = 0;
    tx_data = b; tx_valid = 1'b1;
    while (!tx_ready && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_ready(input int cap);
    int n;
    n = 0;
    while (!tx_ready && n < cap) begin @(negedge clk); n++; end
  endtask

  // period and high time of sck
  task automatic sck_meas(output int per, output int hi);
    int n;
    logic p;
    n = 0; p = sck;
    while (!(p == 1'b0 && sck == 1'b1) && n < 200) begin p = sck; @(negedge clk); n++; end
    per = 0; hi = 0; p = sck;
    do begin
      if (sck) hi++;
      p = sck; @(negedge clk); per++;
    end while (!(p == 1'b0 && sck == 1'b1) && per < 200);
  endtask

  task automatic tx_frame(input logic [7:0] b, input bit nack,
                          output logic [9:0] bits, output int busy);
    int k;
    bits = '1;
    send(b);
    k = 0;
    while (!tx_ready && k < 6000) begin
      if (k >= 16 && ((k - 16) % E) == 0 && ((k - 16) / E) < 10)
        bits[(k - 16) / E] = line;
      card_low = nack && (k >= 336) && (k < 368);
      @(negedge clk); k++;
    end
    card_low = 1'b0;
    busy = k;
  endtask

  // card sends one character; counts cycles the block pulls the line low late in it
  task automatic card_tx(input logic [7:0] b, input bit bad_par, input bit bad_stop,
                         output int dut_low);
    logic [12:0] v;
    dut_low = 0;
    v = {2'b00, bad_stop, (^b) ^ bad_par ^ 1'b1, ~b, 1'b1};
    for (int i = 0; i < 13; i++) begin
      card_low = v[i];
      repeat (E) begin
        @(negedge clk);
        if (i >= 10 && io_low) dut_low++;
      end
    end
    card_low = 1'b0;
  endtask

  task automatic t_reset;
    chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(status == 6'd0, "R1 status", status, 0);
    chk(io_low == 1'b0, "R1 line released", io_low, 0);
  endtask

  task automatic t_clk_default;
    int per, hi;
    sck_meas(per, hi);
    chk(per == 13, "R1 R2 sck period", per, 13);
    chk(hi == 6, "R2 sck high", hi, 6);
  endtask

  task automatic t_etu_default;
    int n;
    send(8'h01);
    n = 0;
    while (!line && n < 6000) begin n++; @(negedge clk); end
    chk(n >= 4820 && n <= 4840, "R1 R3 start bit 372x13", n, 4836);
    chk(status == 6'd0, "R12 status after turnaround", status, 0);
    cfg(2'd0, 16'd2);
    cfg(2'd1, 16'd16);
    wait_ready(3000);
    chk(tx_ready == 1'b1, "R3 reconfigured frame ends", tx_ready, 1);
  endtask

  task automatic t_tx_frames;
    logic [9:0] bits;
    int busy;
    tx_frame(8'hA5, 1'b0, bits, busy);
    chk(bits == {^8'hA5, 8'hA5, 1'b0}, "R4 frame A5", bits, {^8'hA5, 8'hA5, 1'b0});
    chk(busy >= 17*E-3 && busy <= 17*E+3, "R1 R5 guard 5", busy, 17*E);
    chk(status[4] == 1'b0, "R6 no NACK", status[4], 0);
    cfg(2'd2, 16'd0);
    tx_frame(8'h3E, 1'b0, bits, busy);
    chk(bits == {^8'h3E, 8'h3E, 1'b0}, "R4 frame 3E", bits, {^8'h3E, 8'h3E, 1'b0});
    chk(busy >= 12*E-3 && busy <= 12*E+3, "R5 guard 0", busy, 12*E);
  endtask

  task automatic t_nack;
    logic [9:0] bits;
    int busy;
    tx_frame(8'h55, 1'b1, bits, busy);
    chk(status[4] == 1'b1, "R6 NACK flagged", status[4], 1);
  endtask

  task automatic t_switch;
    rx_ready = 1'b1;
    cyc(3);
    chk(status == 6'd0, "R12 cleared on TX to RX", status, 0);
    rx_ready = 1'b0;
    cyc(2);
  endtask

  task automatic t_timeout;
    cfg(2'd3, 16'd4);
    rx_ready = 1'b1;
    cyc(3*E);
    chk(status[3] == 1'b0, "R11 not yet", status[3], 0);
    cyc(E + 16);
    chk(status[3] == 1'b1, "R11 timeout", status[3], 1);
    rx_ready = 1'b0;
    cfg(2'd3, 16'd0);
  endtask

  task automatic t_rx_good;
    int dl;
    card_tx(8'h3C, 1'b0, 1'b0, dl);
    chk(rx_valid == 1'b1, "R7 valid", rx_valid, 1);
    chk(rx_data == 8'h3C, "R7 data", rx_data, 8'h3C);
    chk(dl == 0, "R7 no line drive", dl, 0);
    rx_ready = 1'b1; cyc(1); rx_ready = 1'b0; cyc(1);
    chk(rx_valid == 1'b0, "R7 taken", rx_valid, 0);
  endtask

  task automatic t_rx_par;
    int dl;
    card_tx(8'h5A, 1'b1, 1'b0, dl);
    chk(status[2] == 1'b1, "R8 parity flag", status[2], 1);
    chk(rx_valid == 1'b0, "R8 not presented", rx_valid, 0);
    chk(dl >= E-4 && dl <= E+4, "R8 error pulse length", dl, E);
  endtask

  task automatic t_rx_frm;
    int dl;
    card_tx(8'h81, 1'b0, 1'b1, dl);
    chk(status[1] == 1'b1, "R9 framing flag", status[1], 1);
    chk(rx_valid == 1'b0, "R9 not presented", rx_valid, 0);
  endtask

  task automatic t_ovr;
    int dl;
    card_tx(8'h11, 1'b0, 1'b0, dl);
    chk(status[0] == 1'b0, "R10 no overrun yet", status[0], 0);
    card_tx(8'h22, 1'b0, 1'b0, dl);
    chk(status[0] == 1'b1, "R10 overrun", status[0], 1);
    chk(rx_data == 8'h11, "R10 old byte kept", rx_data, 8'h11);
    rx_ready = 1'b1; cyc(1); rx_ready = 1'b0; cyc(1);
  endtask

  task automatic t_stop;
    int hi, per;
    cfg(2'd0, 16'd0);
    hi = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (sck) hi++; end
    chk(hi == 0, "R2 clock stopped", hi, 0);
    send(8'h77);
    cyc(10);
    chk(status == 6'h20, "R12 R13 cleared then underrun", status, 6'h20);
    chk(tx_ready == 1'b0, "R2 frame frozen", tx_ready, 0);
    cfg(2'd0, 16'd2);
    wait_ready(2000);
    chk(tx_ready == 1'b1, "R2 restart completes frame", tx_ready, 1);
    sck_meas(per, hi);
    chk(per == 2, "R2 restarted period", per, 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_clk_default();
    t_etu_default();
    t_tx_frames();
    t_nack();
    t_switch();
    t_timeout();
    t_rx_good();
    t_rx_par();
    t_rx_frm();
    t_ovr();
    t_stop();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule